// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer (Host Side)

This block sits in the execute stage of a processor. It runs the handshake that passes one instruction to an external coprocessor. When the stage starts a coprocessor or undefined instruction whose condition check passed, the block pulls an active-low issue strobe. It then listens on two shared active-high wires. The first is an absent line, which a coprocessor pulls low to claim the instruction. The second is a busy line, which the claiming coprocessor pulls low when it is ready to finish. Both wires rest high when no handshake is in progress.

The block reaches one of three endings and reports it as a one-cycle outcome code. The outcome is a commit when the strobe, absent and busy are all sampled low on one rising edge. It is an undefined-instruction trap when nothing claimed the instruction by the first edge after the strobe fell. It is an interrupt break-off when an enabled interrupt arrives while the claimed coprocessor is still busy. After a break-off, a retry flag asks the stage to issue the same instruction again once the interrupt has been handled. A commit of an instruction that moves data also raises a transfer-go pulse, so the transfer phase can begin on the next cycle. A data operation needs no such phase.

Top module: `cop_handshake_seq`

## Requirements
- R1: While idle, a rising edge that samples `start` and `cond_pass` both high drives `issue_n` low from that edge on.
- R2: A `start` whose `cond_pass` is low leaves `issue_n` high and `outcome` at idle (2'b00).
- R3: If `cp_absent` is high at the first rising edge after `issue_n` fell, `outcome` becomes trap (2'b10) for exactly one cycle and `issue_n` returns high in that same cycle.
- R4: Once claimed, and while `cp_busy` stays high with no interrupt, `issue_n` stays low and `outcome` stays idle. A late rise of `cp_absent` does not cause a trap.
- R5: An `irq_pending` high at an edge where `issue_n` is low and the handshake does not commit ends the handshake. `outcome` becomes abort (2'b11) for one cycle, `issue_n` goes high, and `retry` goes high. `retry` stays high until the next accepted issue clears it.
- R6: An edge that samples `issue_n`, `cp_absent` and `cp_busy` all low gives `outcome` commit (2'b01) for one cycle with `issue_n` high. This holds even when `irq_pending` is high at that edge.
- R7: In the commit cycle, `xfer_go` is high when `data_op` was low at the accepting edge, and low when `data_op` was high. At all other times `xfer_go` is low.
- R8: A `start` that arrives while a handshake is in progress is ignored.
- R9: During and after reset, `issue_n` is high, `outcome` is idle, and `retry` and `xfer_go` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Execute stage begins a coprocessor or undefined instruction |
| cond_pass | input | 1 | Condition check of that instruction passed |
| data_op | input | 1 | Instruction is a data operation with no transfer phase |
| irq_pending | input | 1 | An enabled interrupt is pending |
| cp_absent | input | 1 | Shared absent line; low means a coprocessor claimed the instruction |
| cp_busy | input | 1 | Shared busy line; low means the claimer is ready to finish |
| issue_n | output | 1 | Active-low instruction-issue strobe |
| outcome | output | 2 | 00 idle, 01 commit, 10 trap, 11 interrupt abort |
| retry | output | 1 | Reissue the abandoned instruction after the interrupt |
| xfer_go | output | 1 | Transfer phase of the committed instruction may start next cycle |

## Verification
The bench targets several edges in the timing:
- **Trap sampling edge.** A coprocessor that claims only after the first edge. A design that samples absent too early or too late would trap too soon, or trap on a late absent rise during the wait.
- **Commit against interrupt.** An edge where busy falls while an interrupt is pending. A design with the wrong priority would abort an instruction that had already committed.
- **Retry persistence.** `retry` is checked across idle cycles after an abort and at the reissue edge. A design that clears it early would lose the instruction, and one that never clears it would retry forever.
- **Ignored inputs.** A second `start` arrives mid-handshake, and a `start` arrives with a failed condition. Mishandling either would show as a spurious strobe or outcome.
- **Data-op flag.** The transfer pulse is compared for data and transfer instructions. This catches a flag that is not latched at issue.

// File: rtl/cop_handshake_seq.sv
module cop_handshake_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cond_pass,
  input  logic       data_op,
  input  logic       irq_pending,
  input  logic       cp_absent,
  input  logic       cp_busy,
  output logic       issue_n,
  output logic [1:0] outcome,
  output logic       retry,
  output logic       xfer_go
);

  localparam logic [1:0] OUT_IDLE   = 2'b00;
  localparam logic [1:0] OUT_COMMIT = 2'b01;
  localparam logic [1:0] OUT_TRAP   = 2'b10;
  localparam logic [1:0] OUT_ABORT  = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_WAIT} st_t;

  st_t  st;
  logic dop_q;

  wire in_hs     = (st != S_IDLE);
  wire launch    = (st == S_IDLE) && start && cond_pass;
  wire unclaimed = (st == S_FIRST) && cp_absent;
  wire done      = in_hs && !cp_absent && !cp_busy;
  wire brk       = in_hs && !unclaimed && !done && irq_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      issue_n <= 1'b1;
      outcome <= OUT_IDLE;
      retry   <= 1'b0;
      xfer_go <= 1'b0;
      dop_q   <= 1'b0;
    end else begin
      outcome <= OUT_IDLE;
      xfer_go <= 1'b0;
      if (launch) begin
        st      <= S_FIRST;
        issue_n <= 1'b0;
        retry   <= 1'b0;
        dop_q   <= data_op;
      end else if (unclaimed) begin
        st      <= S_IDLE;
        issue_n <= 1'b1;
        outcome <= OUT_TRAP;
      end else if (done) begin
        st      <= S_IDLE;
        issue_n <= 1'b1;
        outcome <= OUT_COMMIT;
        xfer_go <= !dop_q;
      end else if (brk) begin
        st      <= S_IDLE;
        issue_n <= 1'b1;
        outcome <= OUT_ABORT;
        retry   <= 1'b1;
      end else if (in_hs) begin
        st      <= S_WAIT;
      end
    end
  end

endmodule

module cop_handshake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       cond_pass,
  input logic       irq_pending,
  input logic       cp_absent,
  input logic       cp_busy,
  input logic       issue_n,
  input logic [1:0] outcome,
  input logic       retry,
  input logic       xfer_go
);

  AST_ISSUE_NEEDS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(issue_n) |-> $past(start && cond_pass)); // R1
  AST_TRAP_ON_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome == 2'b10) |-> ($past(cp_absent) && !$past(issue_n) && issue_n)); // R3
  AST_NO_OUTCOME_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_n |-> (outcome == 2'b00)); // R4
  AST_ABORT_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome == 2'b11) |-> ($past(irq_pending) && !$past(issue_n) && retry && issue_n)); // R5
  AST_RETRY_SET_BY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retry) |-> (outcome == 2'b11)); // R5
  AST_RETRY_CLEARS_AT_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(retry) |-> !issue_n); // R5
  AST_COMMIT_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome == 2'b01) |-> (!$past(issue_n) && !$past(cp_absent) && !$past(cp_busy))); // R6
  AST_XFER_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |-> (outcome == 2'b01)); // R7

endmodule

bind cop_handshake_seq cop_handshake_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cond_pass(cond_pass),
  .irq_pending(irq_pending), .cp_absent(cp_absent), .cp_busy(cp_busy),
  .issue_n(issue_n), .outcome(outcome), .retry(retry), .xfer_go(xfer_go)
);

// File: tb/tb_cop_handshake_seq.sv
`timescale 1ns/1ps
module tb_cop_handshake_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, cond_pass = 0, data_op = 0, irq_pending = 0;
  logic cp_absent = 1, cp_busy = 1;
  logic issue_n, retry, xfer_go;
  logic [1:0] outcome;

  int n_chk = 0, n_fail = 0, cycles = 0;
  string phase = "R9";

  // behavioural reference
  int  m_mode = 0;      // 0 no handshake, 1 just issued, 2 claimed and waiting
  int  m_out = 0;
  bit  m_issue_n = 1, m_retry = 0, m_xfer = 0, m_dop = 0;

  cop_handshake_seq dut (.*);

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_out = 0; m_issue_n = 1; m_retry = 0; m_xfer = 0; m_dop = 0;
    end else begin
      m_out = 0; m_xfer = 0;
      if (m_mode == 0) begin
        if (start && cond_pass) begin
          m_mode = 1; m_issue_n = 0; m_retry = 0; m_dop = data_op;
        end
      end else if (m_mode == 1 && cp_absent) begin
        m_mode = 0; m_issue_n = 1; m_out = 2;
      end else if (!cp_absent && !cp_busy) begin
        m_mode = 0; m_issue_n = 1; m_out = 1; m_xfer = !m_dop;
      end else if (irq_pending) begin
        m_mode = 0; m_issue_n = 1; m_out = 3; m_retry = 1;
      end else m_mode = 2;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check({phase, " issue_n"}, issue_n, m_issue_n);
    check({phase, " outcome"}, outcome, m_out);
    check({phase, " retry"},   retry,   m_retry);
    check({phase, " xfer_go"}, xfer_go, m_xfer);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic idle_lines();
    start = 0; cond_pass = 0; cp_absent = 1; cp_busy = 1; irq_pending = 0; data_op = 0;
  endtask

  initial begin
    step(3);
    check("R9 reset issue_n", issue_n, 1);
    check("R9 reset outcome", outcome, 0);
    rst_n = 1;
    step(2);

    phase = "R2";
    start = 1; cond_pass = 0; step;
    start = 0; step;
    check("R2 no strobe on failed condition", issue_n, 1);
    check("R2 no outcome", outcome, 0);

    phase = "R3";
    start = 1; cond_pass = 1; step;
    start = 0;
    check("R1 strobe low after accept", issue_n, 0);
    step;
    check("R3 trap outcome", outcome, 2);
    check("R3 strobe released", issue_n, 1);
    step;
    check("R3 trap is one cycle", outcome, 0);

    phase = "R6";
    start = 1; cond_pass = 1; cp_absent = 0; cp_busy = 0; step;
    start = 0; step;
    check("R6 immediate commit", outcome, 1);
    check("R7 transfer pulse for non-data op", xfer_go, 1);
    idle_lines(); step;

    phase = "R4";
    start = 1; cond_pass = 1; data_op = 1; cp_absent = 0; step;
    start = 0; data_op = 0;
    for (int i = 0; i < 4; i++) begin
      step;
      check("R4 strobe held while busy", issue_n, 0);
      check("R4 no outcome while busy", outcome, 0);
    end
    phase = "R8";
    start = 1; cond_pass = 1; step; start = 0;
    check("R8 start ignored mid-handshake", outcome, 0);
    phase = "R4";
    cp_absent = 1; step(2);
    check("R4 late absent rise gives no trap", outcome, 0);
    cp_absent = 0; cp_busy = 0; step;
    check("R6 commit after wait", outcome, 1);
    check("R7 no transfer for data op", xfer_go, 0);
    idle_lines(); step;
    check("R8 ignored start left nothing pending", issue_n, 1);

    phase = "R5";
    start = 1; cond_pass = 1; cp_absent = 0; step;
    start = 0; step(2);
    irq_pending = 1; step;
    check("R5 abort outcome", outcome, 3);
    check("R5 retry set", retry, 1);
    check("R5 strobe released", issue_n, 1);
    irq_pending = 0; cp_absent = 1; step(3);
    check("R5 retry persists", retry, 1);
    start = 1; cond_pass = 1; cp_absent = 0; step;
    start = 0;
    check("R5 retry cleared at reissue", retry, 0);
    phase = "R6";
    cp_busy = 0; irq_pending = 1; step;
    check("R6 commit beats interrupt", outcome, 1);
    check("R6 no retry on commit", retry, 0);
    idle_lines(); step;

    phase = "R1";
    start = 1; cond_pass = 1; cp_absent = 0; cp_busy = 0; step(2);
    check("R1 back-to-back commit", outcome, 1);
    step;
    check("R1 start held reissues", issue_n, 0);
    idle_lines(); step(3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule